// File: doc/BRIEF.md
# Hierarchical Configuration Byte Decoder

This block takes configuration traffic arriving one byte at a time on an 8-bit bus qualified by a valid flag. It turns that traffic into write strobes for the register banks of many small operators. Each transaction opens with two header bytes. The first is a location that names a processing element, a module inside it and an operator inside that module. The second says how many payload bytes follow. The decoder removes the header and sends each payload byte to the one addressed operator, together with its position inside the transaction.

Routing is split over four registered levels: header parsing, element select, module select and operator select. Each level narrows a one-hot hit vector by one location field. A byte therefore reaches its operator a fixed number of cycles after it enters. One element ID is reserved for a global bank at the top level. That bank holds the frame width and height and never produces an operator strobe. The whole block runs on the configuration clock, which is separate from any pixel clock.

Top module: `cfg_tree_decoder`

## Requirements
- R1: A synchronous active-high reset clears every strobe, the index and data outputs, and both frame registers to zero. It also returns the parser to waiting for a location byte, even in the middle of a transaction.
- R2: The first valid byte of a transaction is the location: bits [7:4] hold the element ID, bits [3:2] the module ID and bits [1:0] the operator ID. The next valid byte is the payload count. Header bytes never produce a strobe.
- R3: Payload byte k (k = 0..7) of a transaction to element e (e < NUM_PE), module m and operator o raises op_wr_en bit e*16+m*4+o for exactly one cycle. During that cycle op_wr_idx = k and op_wr_data = the byte. The strobe appears in the fourth cycle after the cycle in which the byte is presented.
- R4: A payload count of zero ends the transaction at the header. No strobe follows, and the next valid byte is read as a new location.
- R5: A payload count above eight delivers the first eight bytes with indices 0..7. The next (count-8) valid bytes are then discarded without a strobe, and the byte after them is a new location.
- R6: Element ID 0xF addresses the global bank. Payload indices 0 and 1 load the low and high bytes of the frame width, and indices 2 and 3 load the low and high bytes of the frame height. The new value shows two cycles after the byte is presented. Other indices are ignored, and no operator strobe is raised.
- R7: Payload for an element ID that is neither 0xF nor below NUM_PE raises no strobe.
- R8: At most one op_wr_en bit is high in any cycle. op_wr_idx and op_wr_data read zero whenever no strobe is high.
- R9: Cycles with cfg_valid low are ignored: idle gaps at any point of a transaction leave the resulting strobes, indices and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_byte | input | 8 | Configuration byte |
| cfg_valid | input | 1 | cfg_byte is accepted in this cycle |
| op_wr_en | output | NUM_PE*16 | One-hot operator write strobe, bit e*16+m*4+o |
| op_wr_idx | output | 3 | Payload byte index of the current strobe |
| op_wr_data | output | 8 | Payload byte of the current strobe |
| frame_width | output | FRAME_W | Global frame width |
| frame_height | output | FRAME_W | Global frame height |

## Verification
The hardest state to reach is an over-long transaction that is still discarding its surplus bytes when idle gaps and the next header arrive. The bench must then show that the last discarded byte and the first header byte stay silent. A clean restart after a reset in the middle of a payload is a related case. The stimulus reaches both with directed transactions: counts of exactly 8 and of 12, and a reset after two payload bytes. It follows them with many random transactions whose counts run from 0 to 12, whose targets include the global ID and element IDs beyond NUM_PE, and whose bytes are separated by random valid-low gaps.

// File: rtl/cfg_tree_pkg.sv
package cfg_tree_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAX_PAY   = 8;
    localparam int IDX_W     = $clog2(MAX_PAY);
    localparam int CNT_W     = $clog2(MAX_PAY + 1);
    localparam int PE_ID_W   = 4;
    localparam int MOD_ID_W  = 2;
    localparam int OP_ID_W   = 2;
    localparam int MODS_PER_PE = 1 << MOD_ID_W;
    localparam int OPS_PER_MOD = 1 << OP_ID_W;
    localparam logic [PE_ID_W-1:0] GLOBAL_PE = '1;

    typedef enum logic [1:0] {
        PS_LOC  = 2'd0,
        PS_CNT  = 2'd1,
        PS_PAY  = 2'd2,
        PS_DROP = 2'd3
    } parse_st_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] loc;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } cfg_beat_t;
endpackage

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
    import cfg_tree_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_vld,
    output cfg_beat_t         beat_o
);
    typedef struct packed {
        parse_st_e         st;
        logic [BYTE_W-1:0] loc;
        logic [CNT_W-1:0]  left;
        logic [BYTE_W-1:0] drop;
        logic [IDX_W-1:0]  idx;
        cfg_beat_t         beat;
    } parse_t;

    parse_t q, d;

    always_comb begin
        d = q;
        d.beat = '0;
        if (in_vld) begin
            unique case (q.st)
                PS_LOC: begin
                    d.loc = in_byte;
                    d.st  = PS_CNT;
                end
                PS_CNT: begin
                    d.idx = '0;
                    if (in_byte == '0) begin
                        d.st = PS_LOC;
                    end else begin
                        d.st = PS_PAY;
                        if (in_byte > BYTE_W'(MAX_PAY)) begin
                            d.left = CNT_W'(MAX_PAY);
                            d.drop = in_byte - BYTE_W'(MAX_PAY);
                        end else begin
                            d.left = CNT_W'(in_byte);
                            d.drop = '0;
                        end
                    end
                end
                PS_PAY: begin
                    d.beat.vld  = 1'b1;
                    d.beat.loc  = q.loc;
                    d.beat.idx  = q.idx;
                    d.beat.data = in_byte;
                    d.idx  = q.idx + IDX_W'(1);
                    d.left = q.left - CNT_W'(1);
                    if (q.left == CNT_W'(1))
                        d.st = (q.drop != '0) ? PS_DROP : PS_LOC;
                end
                PS_DROP: begin
                    d.drop = q.drop - BYTE_W'(1);
                    if (q.drop == BYTE_W'(1))
                        d.st = PS_LOC;
                end
                default: d.st = PS_LOC;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= PS_LOC;
        end else begin
            q <= d;
        end
    end

    assign beat_o = q.beat;

    // R2: a location byte never yields a payload beat
    assert_hdr_no_beat_R2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && q.st == PS_LOC) |=> !beat_o.vld);

    // R4: a zero count returns straight to the location wait
    assert_zero_count_R4: assert property (@(posedge clk) disable iff (rst)
        (in_vld && q.st == PS_CNT && in_byte == '0) |=> (q.st == PS_LOC && !beat_o.vld));

    // R5: surplus bytes are swallowed silently
    assert_drop_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (in_vld && q.st == PS_DROP) |=> !beat_o.vld);

    // R9: an idle cycle leaves the parser where it was
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(q.st) && !beat_o.vld));
endmodule

// File: rtl/cfg_global_bank.sv
module cfg_global_bank
    import cfg_tree_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic [FRAME_W-1:0] frame_w,
    output logic [FRAME_W-1:0] frame_h
);
    localparam int FB = FRAME_W / BYTE_W;

    typedef struct packed {
        logic [FRAME_W-1:0] w;
        logic [FRAME_W-1:0] h;
    } glb_t;

    glb_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            for (int b = 0; b < FB; b++) begin
                if (wr_idx == IDX_W'(b))
                    d.w[b*BYTE_W +: BYTE_W] = wr_data;
                if (wr_idx == IDX_W'(FB + b))
                    d.h[b*BYTE_W +: BYTE_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign frame_w = q.w;
    assign frame_h = q.h;

    // R6: global registers only move on a global bank write
    assert_glb_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(frame_w) && $stable(frame_h)));

    // R6: indices past the frame fields change nothing
    assert_glb_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= IDX_W'(2*FB)) |=> ($stable(frame_w) && $stable(frame_h)));
endmodule

// File: rtl/cfg_route_stage.sv
module cfg_route_stage
    import cfg_tree_pkg::*;
#(
    parameter int IN_N    = 1,
    parameter int FAN     = 4,
    parameter int SEL_LSB = 0,
    parameter int SEL_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IN_N-1:0]       hit_i,
    input  logic [BYTE_W-1:0]     loc_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [BYTE_W-1:0]     data_i,
    output logic [IN_N*FAN-1:0]   hit_o,
    output logic [BYTE_W-1:0]     loc_o,
    output logic [IDX_W-1:0]      idx_o,
    output logic [BYTE_W-1:0]     data_o
);
    localparam int OUT_N = IN_N * FAN;

    typedef struct packed {
        logic [OUT_N-1:0]  hit;
        logic [BYTE_W-1:0] loc;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } route_t;

    route_t q, d;
    logic [OUT_N-1:0] hit_d;
    logic [SEL_W-1:0] sel;

    assign sel = loc_i[SEL_LSB +: SEL_W];

    for (genvar i = 0; i < IN_N; i++) begin : g_parent
        for (genvar j = 0; j < FAN; j++) begin : g_child
            assign hit_d[i*FAN + j] = hit_i[i] && (sel == SEL_W'(j));
        end
    end

    always_comb begin
        d.hit  = hit_d;
        d.loc  = loc_i;
        d.idx  = (|hit_d) ? idx_i  : '0;
        d.data = (|hit_d) ? data_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign hit_o  = q.hit;
    assign loc_o  = q.loc;
    assign idx_o  = q.idx;
    assign data_o = q.data;

    // R8: a level never selects two children at once
    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_o));

    // R3: every child hit descends from a parent hit one cycle earlier
    assert_hit_origin_R3: assert property (@(posedge clk) disable iff (rst)
        (|hit_o) |-> $past(|hit_i));
endmodule

// File: rtl/cfg_tree_decoder.sv
module cfg_tree_decoder
    import cfg_tree_pkg::*;
#(
    parameter int NUM_PE  = 4,
    parameter int FRAME_W = 16
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [7:0]                               cfg_byte,
    input  logic                                     cfg_valid,
    output logic [NUM_PE*MODS_PER_PE*OPS_PER_MOD-1:0] op_wr_en,
    output logic [IDX_W-1:0]                         op_wr_idx,
    output logic [7:0]                               op_wr_data,
    output logic [FRAME_W-1:0]                       frame_width,
    output logic [FRAME_W-1:0]                       frame_height
);
    localparam int NUM_MOD = NUM_PE * MODS_PER_PE;
    localparam int NUM_OPS = NUM_MOD * OPS_PER_MOD;

    cfg_beat_t           beat;
    logic [0:0]          hit0;
    logic                glb_wr;

    logic [NUM_PE-1:0]   pe_hit;
    logic [BYTE_W-1:0]   pe_loc, mod_loc, op_loc;
    logic [IDX_W-1:0]    pe_idx, mod_idx;
    logic [BYTE_W-1:0]   pe_data, mod_data;
    logic [NUM_MOD-1:0]  mod_hit;

    cfg_hdr_parser i_parser (
        .clk(clk), .rst(rst),
        .in_byte(cfg_byte), .in_vld(cfg_valid),
        .beat_o(beat)
    );

    assign glb_wr  = beat.vld && (beat.loc[BYTE_W-1 -: PE_ID_W] == GLOBAL_PE);
    assign hit0[0] = beat.vld && !glb_wr;

    cfg_global_bank #(.FRAME_W(FRAME_W)) i_global (
        .clk(clk), .rst(rst),
        .wr_en(glb_wr), .wr_idx(beat.idx), .wr_data(beat.data),
        .frame_w(frame_width), .frame_h(frame_height)
    );

    cfg_route_stage #(.IN_N(1), .FAN(NUM_PE),
                      .SEL_LSB(MOD_ID_W + OP_ID_W), .SEL_W(PE_ID_W)) i_pe_lvl (
        .clk(clk), .rst(rst),
        .hit_i(hit0), .loc_i(beat.loc), .idx_i(beat.idx), .data_i(beat.data),
        .hit_o(pe_hit), .loc_o(pe_loc), .idx_o(pe_idx), .data_o(pe_data)
    );

    cfg_route_stage #(.IN_N(NUM_PE), .FAN(MODS_PER_PE),
                      .SEL_LSB(OP_ID_W), .SEL_W(MOD_ID_W)) i_mod_lvl (
        .clk(clk), .rst(rst),
        .hit_i(pe_hit), .loc_i(pe_loc), .idx_i(pe_idx), .data_i(pe_data),
        .hit_o(mod_hit), .loc_o(mod_loc), .idx_o(mod_idx), .data_o(mod_data)
    );

    cfg_route_stage #(.IN_N(NUM_MOD), .FAN(OPS_PER_MOD),
                      .SEL_LSB(0), .SEL_W(OP_ID_W)) i_op_lvl (
        .clk(clk), .rst(rst),
        .hit_i(mod_hit), .loc_i(mod_loc), .idx_i(mod_idx), .data_i(mod_data),
        .hit_o(op_wr_en), .loc_o(op_loc), .idx_o(op_wr_idx), .data_o(op_wr_data)
    );

    // R3: a strobe sits on the bit named by the location it carried
    assert_strobe_position_R3: assert property (@(posedge clk) disable iff (rst)
        (|op_wr_en) |-> (op_wr_en == (NUM_OPS'(1) << op_loc)));

    // R3: a strobe follows a parsed operator beat by exactly three more registers
    assert_strobe_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (|op_wr_en) |-> $past(hit0[0], 3));

    // R8: outputs read zero with no strobe
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !(|op_wr_en) |-> (op_wr_idx == '0 && op_wr_data == '0));
endmodule

// File: tb/test_cfg_tree_decoder.sv
module test_cfg_tree_decoder;
    localparam int NUM_PE = 4;
    localparam int NOPS   = NUM_PE * 16;
    localparam int FW     = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      cfg_byte = '0;
    logic            cfg_valid = 1'b0;
    logic [NOPS-1:0] op_wr_en;
    logic [2:0]      op_wr_idx;
    logic [7:0]      op_wr_data;
    logic [FW-1:0]   frame_width, frame_height;

    cfg_tree_decoder #(.NUM_PE(NUM_PE), .FRAME_W(FW)) i_cfg_tree_decoder (
        .clk(clk), .rst(rst), .cfg_byte(cfg_byte), .cfg_valid(cfg_valid),
        .op_wr_en(op_wr_en), .op_wr_idx(op_wr_idx), .op_wr_data(op_wr_data),
        .frame_width(frame_width), .frame_height(frame_height)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    // expectation rings, indexed by cycle modulo 16
    int          e_pos [16];
    logic [2:0]  e_idx [16];
    logic [7:0]  e_dat [16];
    string       e_tag [16];
    logic [15:0] h_w [16];
    logic [15:0] h_h [16];

    // bench model of the parser
    int          m_st, m_left, m_drop, m_idx;
    logic [7:0]  m_loc;
    logic [15:0] m_w, m_h;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic clear_rings();
        for (int i = 0; i < 16; i++) begin
            e_pos[i] = -1; e_idx[i] = '0; e_dat[i] = '0; e_tag[i] = "R1";
            h_w[i] = '0; h_h[i] = '0;
        end
        m_st = 0; m_left = 0; m_drop = 0; m_idx = 0; m_loc = '0;
        m_w = '0; m_h = '0;
    endtask

    task automatic compare_now();
        int s;
        int p;
        logic [NOPS-1:0] ev;
        s = cyc & 15;
        p = (cyc - 2) & 15;
        ev = (e_pos[s] >= 0) ? (NOPS'(1) << e_pos[s]) : '0;
        check(e_tag[s], op_wr_en, ev, "strobe");
        check(e_tag[s], op_wr_idx, e_idx[s], "index");
        check(e_tag[s], op_wr_data, e_dat[s], "data");
        check("R6", frame_width, h_w[p], "frame width");
        check("R6", frame_height, h_h[p], "frame height");
        e_pos[s] = -1; e_idx[s] = '0; e_dat[s] = '0; e_tag[s] = "R8";
    endtask

    task automatic model_byte(logic v, logic [7:0] b);
        int t;
        int pe;
        t = (cyc + 4) & 15;
        if (!v) begin
            e_tag[t] = "R9";
        end else begin
            case (m_st)
                0: begin
                    m_loc = b; m_st = 1; e_tag[t] = "R2";
                end
                1: begin
                    if (b == 0) begin
                        m_st = 0; e_tag[t] = "R4";
                    end else begin
                        m_left = (b > 8) ? 8 : int'(b);
                        m_drop = (b > 8) ? int'(b) - 8 : 0;
                        m_idx = 0; m_st = 2; e_tag[t] = "R2";
                    end
                end
                2: begin
                    pe = int'(m_loc[7:4]);
                    if (pe == 15) begin
                        if (m_idx < 2) m_w[m_idx*8 +: 8] = b;
                        else if (m_idx < 4) m_h[(m_idx-2)*8 +: 8] = b;
                        e_tag[t] = "R6";
                    end else if (pe < NUM_PE) begin
                        e_pos[t] = int'(m_loc); e_idx[t] = 3'(m_idx); e_dat[t] = b;
                        e_tag[t] = "R3";
                    end else begin
                        e_tag[t] = "R7";
                    end
                    m_idx++; m_left--;
                    if (m_left == 0) m_st = (m_drop > 0) ? 3 : 0;
                end
                default: begin
                    e_tag[t] = "R5";
                    m_drop--;
                    if (m_drop == 0) m_st = 0;
                end
            endcase
        end
        h_w[cyc & 15] = m_w;
        h_h[cyc & 15] = m_h;
    endtask

    task automatic step(logic v, logic [7:0] b);
        @(negedge clk);
        compare_now();
        cfg_valid = v;
        cfg_byte  = b;
        model_byte(v, b);
    endtask

    task automatic gap(int pct);
        if (pct > 0 && ($urandom % 100) < pct) step(1'b0, 8'($urandom));
    endtask

    task automatic send_txn(logic [7:0] loc, logic [7:0] cnt, int gap_pct);
        step(1'b1, loc);
        gap(gap_pct);
        step(1'b1, cnt);
        for (int k = 0; k < int'(cnt); k++) begin
            gap(gap_pct);
            step(1'b1, 8'($urandom));
        end
    endtask

    task automatic send_bytes(logic [7:0] loc, logic [7:0] b0, logic [7:0] b1,
                              logic [7:0] b2, logic [7:0] b3);
        step(1'b1, loc); step(1'b1, 8'd4);
        step(1'b1, b0); step(1'b1, b1); step(1'b1, b2); step(1'b1, b3);
    endtask

    task automatic flush();
        for (int k = 0; k < 6; k++) step(1'b0, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cfg_valid = 1'b0;
        clear_rings();
        repeat (3) @(negedge clk);
        check("R1", op_wr_en, '0, "strobe in reset");
        check("R1", frame_width, '0, "width in reset");
        check("R1", frame_height, '0, "height in reset");
        rst = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int pe;
        int r;
        void'($urandom(32'd20240611));
        clear_rings();
        do_reset();
        check("R1", op_wr_idx, '0, "index after reset");
        check("R1", op_wr_data, '0, "data after reset");

        // R3: plain transaction to element 0, module 1, operator 2
        send_txn(8'h06, 8'd3, 0);
        flush();
        // R4: zero-count header followed by a normal transaction
        send_txn(8'h21, 8'd0, 0);
        send_txn(8'h3F, 8'd2, 0);
        flush();
        // R3: exactly eight bytes
        send_txn(8'h39, 8'd8, 0);
        flush();
        // R5: twelve bytes, four discarded, then a header right behind
        send_txn(8'h15, 8'd12, 0);
        send_txn(8'h2A, 8'd1, 0);
        flush();
        // R6: global frame size, then extra indices ignored
        send_bytes(8'hF0, 8'h80, 8'h07, 8'h38, 8'h04);
        flush();
        check("R6", frame_width, 16'h0780, "direct width");
        check("R6", frame_height, 16'h0438, "direct height");
        send_txn(8'hF3, 8'd6, 0);
        flush();
        // R7: element ID beyond NUM_PE
        send_txn(8'h5B, 8'd3, 0);
        send_txn(8'hE0, 8'd2, 0);
        flush();
        // R9: gaps everywhere
        send_txn(8'h2D, 8'd10, 60);
        flush();
        // R1: reset in the middle of a payload, then a clean transaction
        step(1'b1, 8'h12); step(1'b1, 8'd5); step(1'b1, 8'hAA); step(1'b1, 8'hBB);
        do_reset();
        check("R1", op_wr_en, '0, "strobe after mid reset");
        send_txn(8'h33, 8'd2, 0);
        flush();

        // random traffic
        for (int n = 0; n < 300; n++) begin
            r = int'($urandom % 8);
            if (r < 4) pe = r;
            else if (r == 4) pe = 15;
            else if (r == 5) pe = NUM_PE + int'($urandom % (15 - NUM_PE));
            else pe = int'($urandom % NUM_PE);
            send_txn({4'(pe), 4'($urandom)}, 8'($urandom % 13), 25);
        end
        flush();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule